// File: doc/BRIEF.md
# SMBus Master Command Sequencer

This block is the command engine of a two-wire bus master. Before a transfer, the host fills a transmit FIFO. The first entry is always the target address byte. Each entry carries a data byte in bits 7:0, and bit 31 flags the entry that ends the write phase. The host then writes a command word that carries:

- a start/busy bit;
- a protocol code;
- a packet-check enable bit;
- a read byte count.

The engine then runs the transfer as a series of byte-level bus operations. It pulls entries from the transmit FIFO and pushes received bytes into a receive FIFO. When the transfer ends, it drops busy, leaves a 3-bit result code on its status output and pulses a done event.

Bit timing on the wire is handled outside this block. The engine talks to a byte-level bus agent: it asks for one operation at a time and gets back a completion pulse, together with NACK and arbitration-loss flags and the received byte.

The transfer length is set by the bit-31 marker in the data stream. It is not a separate count. For a combined write-then-read, the host queues a second address entry (read bit set, marked last). The engine turns that entry into a repeated start and then reads the requested count.

Top module: `smb_cmd_seq`

## Requirements
- R1: A command write with bit 31 set while idle starts a transfer: busy reads 1 one cycle later and result is cleared to 0. A command write with bit 31 clear starts nothing. Command word fields are: protocol in bits 12:9, packet-check enable in bit 8, read count in bits 7:0.
- R2: A command write that arrives while busy is 1 is ignored. The running transfer ends exactly as it would have without it, and no second transfer follows.
- R3: Bus operation codes on byte_kind are 0 = start followed by the byte, 1 = send byte, 2 = receive byte, 3 = stop. Every transfer begins with a kind-0 operation that carries the first transmit entry. Protocol 0 (quick command) sends only that address and then a stop, with result 0.
- R4: Protocol 7 (block write), and any code other than 0, 8 or 10, sends the following entries in order as kind-1 operations. It ends with a stop after the entry with bit 31 set; an address entry that is itself marked ends the transfer right after the address.
- R5: Protocol 8 (block read) performs exactly the read count (0 to 255) of kind-2 operations after the address. It pushes each received byte into the receive FIFO in order and then stops.
- R6: Protocol 10 (process call) sends data entries as kind-1 operations. The marked entry is issued as a kind-0 repeated start, which is followed by the read count of receptions and a stop.
- R7: A NACK on a kind-0 operation ends the transfer with result 2. A NACK on a kind-1 operation ends it with result 3. In both cases a stop is issued.
- R8: Arbitration loss on any operation ends the transfer with result 1 and no stop.
- R9: If the transmit FIFO is empty when the next entry is needed, one underrun pulse is raised for that stall and the engine waits. Entries added later continue the transfer normally.
- R10: A stall that lasts TMO_CYCLES ends with result 5 and a stop. A bus operation that is not completed within TMO_CYCLES ends with result 4 and no stop.
- R11: A byte received while the receive FIFO is full is dropped, and the transfer ends with result 6 and a stop.
- R12: done_evt pulses for exactly one cycle as busy falls. The result code holds steady while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 32 | Command word |
| busy | output | 1 | Start/busy status |
| result | output | 3 | Result code of the last transfer |
| done_evt | output | 1 | One-cycle pulse when busy falls |
| underrun_evt | output | 1 | Pulse when the transmit FIFO runs dry before the final entry |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_entry | input | 32 | Transmit FIFO head entry (byte 7:0, final flag 31) |
| tx_pop | output | 1 | Transmit FIFO pop |
| rx_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Receive FIFO push |
| rx_byte | output | 8 | Byte pushed into the receive FIFO |
| byte_go | output | 1 | Request one bus operation |
| byte_kind | output | 2 | Operation kind (0 start, 1 send, 2 receive, 3 stop) |
| byte_out | output | 8 | Byte for a start or send operation |
| byte_done | input | 1 | Bus operation completed |
| byte_nack | input | 1 | Target did not acknowledge (with byte_done) |
| byte_lost | input | 1 | Arbitration lost (with byte_done) |
| byte_in | input | 8 | Received byte (with byte_done) |

## Verification
The bench runs random transfers across the four protocol codes, with random write lengths and read counts. Each run may inject a NACK or an arbitration loss at a random operation, and a bench model predicts the full operation list, the received bytes and the result code. Directed cases then separate the behaviours that random runs seldom reach:
- a NACK on the repeated address compared with one on a data byte;
- an empty FIFO that is refilled compared with one that is never refilled;
- a bus agent that never answers;
- a receive FIFO that fills up part way;
- a 255-byte read and a zero-byte read;
- a command that is poked in mid-transfer.

// File: rtl/smb_cmd_seq.sv
module smb_cmd_seq #(
  parameter int TMO_CYCLES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_word,
  output logic        busy,
  output logic [2:0]  result,
  output logic        done_evt,
  output logic        underrun_evt,
  input  logic        tx_empty,
  input  logic [31:0] tx_entry,
  output logic        tx_pop,
  input  logic        rx_full,
  output logic        rx_push,
  output logic [7:0]  rx_byte,
  output logic        byte_go,
  output logic [1:0]  byte_kind,
  output logic [7:0]  byte_out,
  input  logic        byte_done,
  input  logic        byte_nack,
  input  logic        byte_lost,
  input  logic [7:0]  byte_in
);
  localparam int TW = $clog2(TMO_CYCLES + 1);
  localparam logic [3:0] P_QUICK = 4'd0, P_READ = 4'd8, P_CALL = 4'd10;
  localparam logic [1:0] K_START = 2'd0, K_SEND = 2'd1, K_RECV = 2'd2, K_STOP = 2'd3;
  localparam logic [2:0] R_OK = 3'd0, R_ARB = 3'd1, R_NADDR = 3'd2, R_NDATA = 3'd3,
                         R_TMO = 3'd4, R_UNDER = 3'd5, R_RXFULL = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_TXD, S_TWAIT, S_RX, S_RWAIT, S_STOP, S_SWAIT} st_t;

  st_t         st;
  logic [3:0]  proto;
  logic [7:0]  rcnt;
  logic [TW-1:0] tmo;
  logic        first_addr, was_start, was_last, stalled;

  wire unused_bits = ^{cmd_word[30:13], cmd_word[8], tx_entry[30:8]};
  wire tmo_hit  = (tmo == TW'(TMO_CYCLES - 1));
  wire fetching = (st == S_ADDR) || (st == S_TXD);
  wire as_start = (st == S_ADDR) || (proto == P_CALL && tx_entry[31]);
  assign tx_pop = fetching && !tx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; busy <= 1'b0; result <= R_OK; done_evt <= 1'b0; underrun_evt <= 1'b0;
      rx_push <= 1'b0; rx_byte <= '0; byte_go <= 1'b0; byte_kind <= K_START; byte_out <= '0;
      proto <= '0; rcnt <= '0; tmo <= '0;
      first_addr <= 1'b0; was_start <= 1'b0; was_last <= 1'b0; stalled <= 1'b0;
    end else begin
      done_evt <= 1'b0; underrun_evt <= 1'b0; rx_push <= 1'b0; byte_go <= 1'b0;
      tmo <= tmo + 1'b1;
      case (st)
        S_IDLE: if (cmd_wr && cmd_word[31]) begin
          busy <= 1'b1; result <= R_OK; proto <= cmd_word[12:9]; rcnt <= cmd_word[7:0];
          stalled <= 1'b0; tmo <= '0; st <= S_ADDR;
        end
        S_ADDR, S_TXD: if (!tx_empty) begin
          byte_go <= 1'b1; byte_kind <= as_start ? K_START : K_SEND; byte_out <= tx_entry[7:0];
          was_start <= as_start; was_last <= tx_entry[31]; first_addr <= (st == S_ADDR);
          stalled <= 1'b0; tmo <= '0; st <= S_TWAIT;
        end else begin
          underrun_evt <= !stalled; stalled <= 1'b1;
          if (tmo_hit) begin result <= R_UNDER; tmo <= '0; st <= S_STOP; end
        end
        S_TWAIT: if (byte_done) begin
          tmo <= '0;
          if (byte_lost) begin
            result <= R_ARB; busy <= 1'b0; done_evt <= 1'b1; st <= S_IDLE;
          end else if (byte_nack) begin
            result <= was_start ? R_NADDR : R_NDATA; st <= S_STOP;
          end else if (proto == P_QUICK) st <= S_STOP;
          else if (was_start && (proto == P_READ || !first_addr)) st <= S_RX;
          else if (was_last) st <= S_STOP;
          else st <= S_TXD;
        end else if (tmo_hit) begin
          result <= R_TMO; busy <= 1'b0; done_evt <= 1'b1; st <= S_IDLE;
        end
        S_RX: if (rcnt == 8'd0) st <= S_STOP;
          else begin byte_go <= 1'b1; byte_kind <= K_RECV; tmo <= '0; st <= S_RWAIT; end
        S_RWAIT: if (byte_done) begin
          tmo <= '0;
          if (byte_lost) begin
            result <= R_ARB; busy <= 1'b0; done_evt <= 1'b1; st <= S_IDLE;
          end else if (rx_full) begin
            result <= R_RXFULL; st <= S_STOP;
          end else begin
            rx_push <= 1'b1; rx_byte <= byte_in; rcnt <= rcnt - 1'b1; st <= S_RX;
          end
        end else if (tmo_hit) begin
          result <= R_TMO; busy <= 1'b0; done_evt <= 1'b1; st <= S_IDLE;
        end
        S_STOP: begin byte_go <= 1'b1; byte_kind <= K_STOP; tmo <= '0; st <= S_SWAIT; end
        S_SWAIT: if (byte_done || tmo_hit) begin
          if (!byte_done && result == R_OK) result <= R_TMO;
          busy <= 1'b0; done_evt <= 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R12
  done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> (!busy && $past(busy)));
  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(result));
  // R2
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(proto));
  // R9
  underrun_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_evt |-> (busy && $past(tx_empty)));
  // R11
  rx_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> $past(!rx_full));
  // R3
  pop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> busy);
  // R3
  go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_go |=> !byte_go);
endmodule

// File: tb/tb_smb_cmd_seq.sv
module tb_smb_cmd_seq;
  localparam int TMO = 64;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, cmd_wr = 1'b0;
  logic [31:0] cmd_word = '0;
  logic busy, done_evt, underrun_evt, tx_pop, rx_push, byte_go;
  logic [2:0] result;
  logic [7:0] rx_byte, byte_out;
  logic [1:0] byte_kind;
  logic byte_done = 1'b0, byte_nack = 1'b0, byte_lost = 1'b0;
  logic [7:0] byte_in = '0;

  logic [31:0] txq [0:511];
  int tx_wr = 0, tx_rd = 0;
  logic flush_req = 1'b0;
  logic tx_empty;
  logic [31:0] tx_entry;
  assign tx_empty = (tx_wr == tx_rd);
  assign tx_entry = txq[tx_rd[8:0]];

  logic [7:0] rxm [0:511];
  int rx_wr = 0, rx_rd = 0, rx_cap = 400;
  logic rx_full;
  assign rx_full = (rx_wr - rx_rd) >= rx_cap;

  smb_cmd_seq #(.TMO_CYCLES(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word), .busy(busy),
    .result(result), .done_evt(done_evt), .underrun_evt(underrun_evt),
    .tx_empty(tx_empty), .tx_entry(tx_entry), .tx_pop(tx_pop),
    .rx_full(rx_full), .rx_push(rx_push), .rx_byte(rx_byte),
    .byte_go(byte_go), .byte_kind(byte_kind), .byte_out(byte_out),
    .byte_done(byte_done), .byte_nack(byte_nack), .byte_lost(byte_lost), .byte_in(byte_in));

  logic [1:0] lk [0:4095];
  logic [7:0] lb [0:4095];
  int op_n = 0, cur = 0, dly = 0, done_n = 0, und_n = 0, cyc = 0;
  int nack_abs = -1, lost_abs = -1, hang_abs = -1;
  int checks = 0, fails = 0;
  logic pend = 1'b0;

  always @(posedge clk) begin
    if (flush_req) tx_rd <= tx_wr; else if (tx_pop) tx_rd <= tx_rd + 1;
    if (rx_push) begin rxm[rx_wr[8:0]] <= rx_byte; rx_wr <= rx_wr + 1; end
    if (done_evt) done_n <= done_n + 1;
    if (underrun_evt) und_n <= und_n + 1;
    byte_done <= 1'b0; byte_nack <= 1'b0; byte_lost <= 1'b0;
    if (flush_req) pend <= 1'b0;
    else if (byte_go) begin
      lk[op_n[11:0]] <= byte_kind; lb[op_n[11:0]] <= byte_out;
      cur <= op_n; op_n <= op_n + 1; pend <= 1'b1; dly <= 1 + int'($urandom % 3);
    end else if (pend) begin
      if (dly > 1) dly <= dly - 1;
      else if (cur != hang_abs) begin
        pend <= 1'b0; byte_done <= 1'b1;
        byte_nack <= (cur == nack_abs); byte_lost <= (cur == lost_abs);
        byte_in <= cur[7:0] ^ 8'h5C;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      $display("FAIL watchdog: actual cycle %0d expected under 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: actual %0d expected %0d", tag, act, exp); end
  endtask

  int ent_n, ex_n, ex_res, ex_rxn, ex_und;
  logic [31:0] ent [0:511];
  logic [1:0] ex_k [0:511];
  logic [7:0] ex_b [0:511];
  int ex_rxi [0:511];

  function automatic bit is_wr_type(input int p);
    return !(p == 0 || p == 8 || p == 10);
  endfunction

  task automatic plan(input int p, input int nwr, input int rcnt, input int nk, input int ls, input int hg);
    logic [1:0] rk [0:511];
    logic [7:0] rb [0:511];
    int rn = 0, pushed = 0;
    bit stop = 1'b1;
    logic [7:0] a;
    a = {7'($urandom % 128), (p == 8) ? 1'b1 : (p == 0 ? 1'($urandom % 2) : 1'b0)};
    ent_n = 0;
    ent[ent_n++] = {(p == 0 || p == 8 || (is_wr_type(p) && nwr == 0)), 23'd0, a};
    rk[rn] = 2'd0; rb[rn++] = a;
    if (p != 0 && p != 8) for (int i = 0; i < nwr; i++) begin
      logic [7:0] d = 8'($urandom);
      ent[ent_n++] = {(p != 10 && i == nwr - 1), 23'd0, d};
      rk[rn] = 2'd1; rb[rn++] = d;
    end
    if (p == 10) begin
      ent[ent_n++] = {1'b1, 23'd0, a[7:1], 1'b1};
      rk[rn] = 2'd0; rb[rn++] = {a[7:1], 1'b1};
    end
    if (p == 8 || p == 10) for (int i = 0; i < rcnt; i++) begin rk[rn] = 2'd2; rb[rn++] = 8'd0; end
    ex_n = 0; ex_res = 0; ex_rxn = 0; ex_und = 0;
    for (int i = 0; i < rn; i++) begin
      ex_k[ex_n] = rk[i]; ex_b[ex_n++] = rb[i];
      if (i == ls) begin ex_res = 1; stop = 1'b0; break; end
      if (i == hg) begin ex_res = 4; stop = 1'b0; break; end
      if (i == nk) begin ex_res = (rk[i] == 2'd0) ? 2 : 3; break; end
      if (rk[i] == 2'd2) begin
        if (pushed >= rx_cap) begin ex_res = 6; break; end
        ex_rxi[ex_rxn++] = i; pushed++;
      end
    end
    if (stop) begin ex_k[ex_n] = 2'd3; ex_b[ex_n++] = 8'd0; end
  endtask

  task automatic prep(input int nk, input int ls, input int hg, output int base);
    @(negedge clk); flush_req = 1'b1; @(negedge clk); flush_req = 1'b0; rx_rd = rx_wr;
    @(negedge clk);
    base = op_n;
    nack_abs = (nk < 0) ? -1 : base + nk;
    lost_abs = (ls < 0) ? -1 : base + ls;
    hang_abs = (hg < 0) ? -1 : base + hg;
  endtask

  task automatic start_cmd(input int p, input int rcnt);
    @(negedge clk); cmd_wr = 1'b1; cmd_word = {1'b1, 18'd0, 4'(p), 1'b0, 8'(rcnt)};
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int k = 0;
    while (busy && k < 5000) begin @(negedge clk); k++; end
    chk(k < 5000, {tag, " completion"}, k, 5000);
  endtask

  task automatic compare(input string tag, input int base, input int d0, input int u0, input int rx0);
    int bad = 0;
    repeat (2) @(negedge clk);
    chk(result == 3'(ex_res), {tag, " result"}, int'(result), ex_res);
    chk(op_n - base == ex_n, {tag, " op count"}, op_n - base, ex_n);
    for (int i = 0; i < ex_n && i < op_n - base; i++) begin
      int j = base + i;
      if (lk[j[11:0]] != ex_k[i] || (ex_k[i] < 2'd2 && lb[j[11:0]] != ex_b[i])) bad++;
    end
    chk(bad == 0, {tag, " op sequence"}, bad, 0);
    chk(rx_wr - rx0 == ex_rxn, {tag, " rx count"}, rx_wr - rx0, ex_rxn);
    bad = 0;
    for (int j = 0; j < ex_rxn && j < rx_wr - rx0; j++) begin
      int q = rx0 + j;
      int v = base + ex_rxi[j];
      if (rxm[q[8:0]] != (v[7:0] ^ 8'h5C)) bad++;
    end
    chk(bad == 0, {tag, " rx data"}, bad, 0);
    chk(done_n - d0 == 1, {tag, " R12 done pulses"}, done_n - d0, 1);
    chk(und_n - u0 == ex_und, {tag, " R9 underrun pulses"}, und_n - u0, ex_und);
  endtask

  task automatic run(input int p, input int nwr, input int rcnt, input int nk, input int ls,
                     input int hg, input bit poke, input string tag);
    int base, d0, u0, rx0;
    prep(nk, ls, hg, base);
    plan(p, nwr, rcnt, nk, ls, hg);
    for (int i = 0; i < ent_n; i++) begin txq[tx_wr[8:0]] = ent[i]; tx_wr++; end
    d0 = done_n; u0 = und_n; rx0 = rx_wr;
    start_cmd(p, rcnt);
    if (poke) begin
      chk(busy == 1'b1, "R2 busy before poke", int'(busy), 1);
      cmd_wr = 1'b1; cmd_word = {1'b1, 18'd0, 4'd0, 1'b0, 8'd0};
      @(negedge clk); cmd_wr = 1'b0;
    end
    wait_idle(tag);
    compare(tag, base, d0, u0, rx0);
  endtask

  initial begin
    int unsigned sd;
    int base, d0, u0, rx0, k;
    logic [2:0] held;
    sd = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    chk(result == 3'd0, "R1 reset result", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: command without start bit
    base = op_n;
    @(negedge clk); cmd_wr = 1'b1; cmd_word = {1'b0, 18'd0, 4'd7, 1'b0, 8'd3};
    @(negedge clk); cmd_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && op_n == base, "R1 no start bit", int'(busy), 0);

    // R1: busy one cycle after command
    prep(-1, -1, -1, base);
    plan(0, 0, 0, -1, -1, -1);
    txq[tx_wr[8:0]] = ent[0]; tx_wr++;
    d0 = done_n; u0 = und_n; rx0 = rx_wr;
    start_cmd(0, 0);
    chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
    wait_idle("R3 quick");
    compare("R3 quick", base, d0, u0, rx0);

    for (int n = 0; n < 40; n++) begin
      int sel = int'($urandom % 4);
      int p = (sel == 0) ? 0 : (sel == 1) ? 7 : (sel == 2) ? 8 : 10;
      int nwr = int'($urandom % 9);
      int rc = int'($urandom % 10);
      int inj = int'($urandom % 6);
      int ns = (p == 0 || p == 8) ? 1 : (p == 7) ? 1 + nwr : 2 + nwr;
      int nk = (inj == 0) ? int'($urandom % ns) : -1;
      int ls = (inj == 1) ? int'($urandom % ns) : -1;
      string t = (p == 0) ? "R3 rand quick" : (p == 7) ? "R4 rand write" :
                 (p == 8) ? "R5 rand read" : "R6 rand call";
      if (inj == 0) t = {t, " R7 nack"};
      if (inj == 1) t = {t, " R8 lost"};
      run(p, nwr, rc, nk, ls, -1, 1'b0, t);
    end

    run(3, 4, 0, -1, -1, -1, 1'b0, "R4 unknown code as write");
    run(7, 0, 0, -1, -1, -1, 1'b0, "R4 marked address");
    run(8, 0, 255, -1, -1, -1, 1'b0, "R5 read 255");
    run(8, 0, 0, -1, -1, -1, 1'b0, "R5 read zero");
    run(10, 3, 4, -1, -1, -1, 1'b0, "R6 process call");
    run(8, 0, 3, 0, -1, -1, 1'b0, "R7 address nack");
    run(7, 5, 0, 3, -1, -1, 1'b0, "R7 data nack");
    run(10, 2, 4, 3, -1, -1, 1'b0, "R7 repeated address nack");
    run(7, 3, 0, -1, 0, -1, 1'b0, "R8 lost on address");
    run(10, 2, 5, -1, 4, -1, 1'b0, "R8 lost during call");
    run(7, 4, 0, -1, -1, 2, 1'b0, "R10 bus timeout");
    run(8, 0, 6, -1, -1, -1, 1'b1, "R2 poke while busy");
    k = 0;
    repeat (4) begin @(negedge clk); if (busy) k++; end
    chk(k == 0, "R2 no queued transfer", k, 0);

    rx_cap = 16;
    run(8, 0, 20, -1, -1, -1, 1'b0, "R11 receive full");
    rx_cap = 400;

    // R12: result holds while idle
    held = result;
    repeat (6) @(negedge clk);
    chk(result == held, "R12 result hold", int'(result), int'(held));

    // R9: stall then refill
    prep(-1, -1, -1, base);
    plan(7, 5, 0, -1, -1, -1);
    for (int i = 0; i < 3; i++) begin txq[tx_wr[8:0]] = ent[i]; tx_wr++; end
    d0 = done_n; u0 = und_n; rx0 = rx_wr;
    start_cmd(7, 0);
    k = 0;
    while (und_n == u0 && k < 200) begin @(negedge clk); k++; end
    repeat (10) @(negedge clk);
    chk(busy == 1'b1, "R9 waits during stall", int'(busy), 1);
    for (int i = 3; i < ent_n; i++) begin txq[tx_wr[8:0]] = ent[i]; tx_wr++; end
    wait_idle("R9 refill");
    ex_und = 1;
    compare("R9 refill", base, d0, u0, rx0);

    // R10: stall never refilled
    prep(-1, -1, -1, base);
    plan(7, 3, 0, -1, -1, -1);
    for (int i = 0; i < 2; i++) begin txq[tx_wr[8:0]] = ent[i]; tx_wr++; end
    d0 = done_n; u0 = und_n; rx0 = rx_wr;
    start_cmd(7, 0);
    wait_idle("R10 stall timeout");
    ex_n = 3; ex_k[2] = 2'd3; ex_res = 5; ex_rxn = 0; ex_und = 1;
    compare("R10 stall timeout", base, d0, u0, rx0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule